// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each cycle it takes per-channel fire and clear strobes, together with each channel's configuration (enable, trigger type, line route, message-delivery enable and message target), and turns them into levels and pulses on 32 interrupt lines. It also keeps one status bit per channel and can issue 32-bit message writes in place of line interrupts. Software clears status bits by writing ones to them. Comparators and register decoding live outside; this block only sees the decoded strobes and fields.

A legacy replacement mode gives channels 0 and 1 fixed lines, 0 and 8, and suppresses the external PIT and RTC interrupt inputs that otherwise pass through to those same lines. The block samples the RTC input at all times, so that when legacy mode is left, line 8 comes back at the current RTC level. A PIT-enable output tells the old interval timer whether it still owns its line.

Top module: `irq_router`

## Requirements
- R1: While `legacyEn` is high, channel 0 routes to line 0 and channel 1 to line 8. Every other channel, and every channel outside legacy mode, routes to the line numbered by its 5-bit field in `chRoute` (channel i at bits [5i+4:5i]).
- R2: A fire on an enabled level-type channel (`chLevel` bit 1) sets its `status` bit and holds its line high from the next cycle. A fire on an edge-type channel (bit 0) leaves `status` clear and raises its line for exactly one cycle.
- R3: A fire on a channel with `chMsgEn` set presents one message with `msgAddr` = bits [64i+63:64i+32] and `msgData` = bits [64i+31:64i] of `chMsgRoute`. It changes no line and no status bit.
- R4: A clear strobe, the falling edge of a channel's enable, or the falling edge of `globalEn` clears the channel's status bit and lowers its line, unless the channel uses message delivery. A fire while the channel or `globalEn` is off has no effect.
- R5: A status write clears exactly those `status` bits that are written as one and currently set, and lowers the matching lines. Bits written as zero are unchanged.
- R6: The cycle after `legacyEn` rises, `pitEnable` is low and lines 0 and 8 are low.
- R7: The cycle after `legacyEn` falls, `pitEnable` is high, line 0 is low (with PIT input low) and line 8 equals the last sampled `rtcIn` level.
- R8: Outside legacy mode, `pitIn` and `rtcIn` appear on lines 0 and 8 one cycle later. In legacy mode they are blocked, but `rtcIn` is still sampled every cycle.
- R9: `msgValid` with its address and data holds stable until `msgReady` is seen high. A fire arriving meanwhile is queued and issued after the acceptance.
- R10: When a channel's `chMsgEn` rises, its status bit is cleared and its line lowered in the next cycle.
- R11: After reset, all lines are low, `status` is zero, `pitEnable` is high and `msgValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Global timer enable |
| legacyEn | input | 1 | Legacy replacement mode select |
| chEnable | input | NUM_CH | Per-channel enable |
| chLevel | input | NUM_CH | Per-channel trigger type (1 level, 0 edge) |
| chMsgEn | input | NUM_CH | Per-channel message-delivery enable |
| chRoute | input | NUM_CH*5 | Per-channel line number |
| chMsgRoute | input | NUM_CH*64 | Per-channel message target: address high, data low |
| fireStb | input | NUM_CH | Per-channel fire strobe |
| clearStb | input | NUM_CH | Per-channel clear strobe |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | NUM_CH | Status write data (ones clear) |
| pitIn | input | 1 | External PIT interrupt input |
| rtcIn | input | 1 | External RTC interrupt input |
| msgReady | input | 1 | Message port ready |
| irqLines | output | 32 | Interrupt output lines |
| status | output | NUM_CH | Per-channel interrupt status |
| pitEnable | output | 1 | PIT ownership of its line |
| msgValid | output | 1 | Message valid |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
Every output is driven by a register, so any wrong internal state shows up at the ports in the cycle right after the strobe that caused it. A held line that failed to clear stays high where a low is expected. A pulse register that failed to drop shows an edge interrupt lasting two cycles. A wrong legacy or RTC state shows on lines 0 and 8 and on `pitEnable` in the cycle after the mode changes. A lost or mis-ordered message pending bit shows as a missing or swapped address and data on the transfer that follows acceptance.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINE_COUNT = 32;
  localparam int LINE_IDX_W = $clog2(LINE_COUNT);
  localparam int PIT_LINE   = 0;
  localparam int RTC_LINE   = 8;
  localparam int MSG_HALF_W = 32;
  localparam int MSG_W      = 2 * MSG_HALF_W;

  typedef struct packed {
    logic [LINE_COUNT-1:0] raiseLevel;
    logic [LINE_COUNT-1:0] raisePulse;
    logic [LINE_COUNT-1:0] lower;
    logic                  legEnter;
    logic                  legLeave;
  } lineStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           globalEn,
  input  logic                           legacyEn,
  input  logic [NUM_CH-1:0]              chEnable,
  input  logic [NUM_CH-1:0]              chLevel,
  input  logic [NUM_CH-1:0]              chMsgEn,
  input  logic [NUM_CH*LINE_IDX_W-1:0]   chRoute,
  input  logic [NUM_CH-1:0]              fireStb,
  input  logic [NUM_CH-1:0]              clearStb,
  input  logic                           stsWrEn,
  input  logic [NUM_CH-1:0]              stsWrData,
  input  logic [NUM_CH-1:0]              status,
  output lineStrobe_t                    lineStb,
  output logic [NUM_CH-1:0]              stsSet,
  output logic [NUM_CH-1:0]              stsClr,
  output logic [NUM_CH-1:0]              msgFire
);
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] msgEnQ;
  logic              globalQ;
  logic              legQ;

  logic [NUM_CH-1:0] fireOk;
  logic [NUM_CH-1:0] deassert;
  logic [NUM_CH-1:0] msgRise;
  logic [LINE_IDX_W-1:0] effRoute [NUM_CH];

  // Route selection: legacy mode pins the first two channels.
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_route
      if (g == 0) begin : g_pit
        assign effRoute[g] = legacyEn ? LINE_IDX_W'(PIT_LINE)
                                      : chRoute[g*LINE_IDX_W +: LINE_IDX_W];
      end else if (g == 1) begin : g_rtc
        assign effRoute[g] = legacyEn ? LINE_IDX_W'(RTC_LINE)
                                      : chRoute[g*LINE_IDX_W +: LINE_IDX_W];
      end else begin : g_plain
        assign effRoute[g] = chRoute[g*LINE_IDX_W +: LINE_IDX_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ     <= '0;
      msgEnQ  <= '0;
      globalQ <= 1'b0;
      legQ    <= 1'b0;
    end else begin
      enQ     <= chEnable;
      msgEnQ  <= chMsgEn;
      globalQ <= globalEn;
      legQ    <= legacyEn;
    end
  end

  always_comb begin
    lineStb = '0;
    stsSet  = '0;
    stsClr  = '0;
    msgFire = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      fireOk[i]   = fireStb[i] & chEnable[i] & globalEn;
      msgRise[i]  = chMsgEn[i] & ~msgEnQ[i];
      deassert[i] = clearStb[i]
                  | (enQ[i] & ~chEnable[i])
                  | (globalQ & ~globalEn)
                  | (stsWrEn & stsWrData[i] & status[i])
                  | msgRise[i];
      stsClr[i]  = deassert[i];
      msgFire[i] = fireOk[i] & chMsgEn[i];
      stsSet[i]  = fireOk[i] & ~chMsgEn[i] & chLevel[i];
      if (deassert[i] && (!chMsgEn[i] || msgRise[i]))
        lineStb.lower[effRoute[i]] = 1'b1;
      if (stsSet[i])
        lineStb.raiseLevel[effRoute[i]] = 1'b1;
      if (fireOk[i] && !chMsgEn[i] && !chLevel[i])
        lineStb.raisePulse[effRoute[i]] = 1'b1;
    end
    lineStb.legEnter = legacyEn & ~legQ;
    lineStb.legLeave = ~legacyEn & legQ;
    if (lineStb.legEnter || lineStb.legLeave) begin
      lineStb.lower[PIT_LINE] = 1'b1;
      lineStb.lower[RTC_LINE] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  lineStrobe_t                lineStb,
  input  logic [NUM_CH-1:0]          stsSet,
  input  logic [NUM_CH-1:0]          stsClr,
  input  logic [NUM_CH-1:0]          msgFire,
  input  logic [NUM_CH*MSG_W-1:0]    chMsgRoute,
  input  logic                       pitIn,
  input  logic                       rtcIn,
  input  logic                       msgReady,
  output logic [LINE_COUNT-1:0]      irqLines,
  output logic [NUM_CH-1:0]          status,
  output logic                       pitEnable,
  output logic                       msgValid,
  output logic [MSG_HALF_W-1:0]      msgAddr,
  output logic [MSG_HALF_W-1:0]      msgData
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [LINE_COUNT-1:0] lineLevel;
  logic [LINE_COUNT-1:0] pulseQ;
  logic                  legacyQ;
  logic                  pitReg;
  logic                  rtcLevel;
  logic [NUM_CH-1:0]     pend;
  logic [NUM_CH-1:0]     pendAll;
  logic [IDX_W-1:0]      pick;
  logic                  found;
  logic                  slotFree;
  logic [LINE_COUNT-1:0] passLines;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineLevel <= '0;
      pulseQ    <= '0;
      status    <= '0;
      legacyQ   <= 1'b0;
      pitEnable <= 1'b1;
      pitReg    <= 1'b0;
      rtcLevel  <= 1'b0;
    end else begin
      lineLevel <= (lineLevel & ~lineStb.lower) | lineStb.raiseLevel;
      pulseQ    <= lineStb.raisePulse;
      status    <= (status & ~stsClr) | stsSet;
      pitReg    <= pitIn;
      rtcLevel  <= rtcIn;
      if (lineStb.legEnter) begin
        legacyQ   <= 1'b1;
        pitEnable <= 1'b0;
      end else if (lineStb.legLeave) begin
        legacyQ   <= 1'b0;
        pitEnable <= 1'b1;
      end
    end
  end

  always_comb begin
    passLines = '0;
    passLines[PIT_LINE] = ~legacyQ & pitReg;
    passLines[RTC_LINE] = ~legacyQ & rtcLevel;
  end

  assign irqLines = lineLevel | pulseQ | passLines;

  // Message port: lowest pending channel wins when the slot frees.
  assign pendAll  = pend | msgFire;
  assign slotFree = ~msgValid | msgReady;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && pendAll[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else if (slotFree) begin
      msgValid <= found;
      if (found) begin
        msgAddr <= chMsgRoute[int'(pick)*MSG_W + MSG_HALF_W +: MSG_HALF_W];
        msgData <= chMsgRoute[int'(pick)*MSG_W +: MSG_HALF_W];
        pend    <= pendAll & ~(NUM_CH'(1) << pick);
      end else begin
        pend    <= pendAll;
      end
    end else begin
      pend <= pendAll;
    end
  end

  // R9: an offered message stays put until accepted
  a_r9_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  // R11: reset leaves PIT ownership with the old timer and no message
  a_r11_reset_state: assert property (@(posedge clk)
    $past(!rst_n) |-> (pitEnable && !msgValid && status == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            globalEn,
  input  logic                            legacyEn,
  input  logic [NUM_CH-1:0]               chEnable,
  input  logic [NUM_CH-1:0]               chLevel,
  input  logic [NUM_CH-1:0]               chMsgEn,
  input  logic [NUM_CH*LINE_IDX_W-1:0]    chRoute,
  input  logic [NUM_CH*MSG_W-1:0]         chMsgRoute,
  input  logic [NUM_CH-1:0]               fireStb,
  input  logic [NUM_CH-1:0]               clearStb,
  input  logic                            stsWrEn,
  input  logic [NUM_CH-1:0]               stsWrData,
  input  logic                            pitIn,
  input  logic                            rtcIn,
  input  logic                            msgReady,
  output logic [LINE_COUNT-1:0]           irqLines,
  output logic [NUM_CH-1:0]               status,
  output logic                            pitEnable,
  output logic                            msgValid,
  output logic [MSG_HALF_W-1:0]           msgAddr,
  output logic [MSG_HALF_W-1:0]           msgData
);
  lineStrobe_t       lineStb;
  logic [NUM_CH-1:0] stsSet;
  logic [NUM_CH-1:0] stsClr;
  logic [NUM_CH-1:0] msgFire;

  irq_router_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .globalEn  (globalEn),
    .legacyEn  (legacyEn),
    .chEnable  (chEnable),
    .chLevel   (chLevel),
    .chMsgEn   (chMsgEn),
    .chRoute   (chRoute),
    .fireStb   (fireStb),
    .clearStb  (clearStb),
    .stsWrEn   (stsWrEn),
    .stsWrData (stsWrData),
    .status    (status),
    .lineStb   (lineStb),
    .stsSet    (stsSet),
    .stsClr    (stsClr),
    .msgFire   (msgFire)
  );

  irq_router_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lineStb    (lineStb),
    .stsSet     (stsSet),
    .stsClr     (stsClr),
    .msgFire    (msgFire),
    .chMsgRoute (chMsgRoute),
    .pitIn      (pitIn),
    .rtcIn      (rtcIn),
    .msgReady   (msgReady),
    .irqLines   (irqLines),
    .status     (status),
    .pitEnable  (pitEnable),
    .msgValid   (msgValid),
    .msgAddr    (msgAddr),
    .msgData    (msgData)
  );

  // R5: written-one bits are clear afterwards when no fire competes
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stsWrEn && fireStb == '0) |=> ((status & $past(stsWrData)) == '0));

  // R4: dropping the global enable empties the status register
  a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(globalEn) |=> (status == '0));

  // R6: entering legacy mode takes the line away from the PIT
  a_r6_legacy_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacyEn) |=> !pitEnable);

  // R7: leaving legacy mode hands the line back
  a_r7_legacy_leave: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(legacyEn) |=> pitEnable);
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            globalEn = 1'b0;
  logic            legacyEn = 1'b0;
  logic [NCH-1:0]  chEnable = '0;
  logic [NCH-1:0]  chLevel = '0;
  logic [NCH-1:0]  chMsgEn = '0;
  logic [NCH*5-1:0]  chRoute;
  logic [NCH*64-1:0] chMsgRoute;
  logic [NCH-1:0]  fireStb = '0;
  logic [NCH-1:0]  clearStb = '0;
  logic            stsWrEn = 1'b0;
  logic [NCH-1:0]  stsWrData = '0;
  logic            pitIn = 1'b0;
  logic            rtcIn = 1'b0;
  logic            msgReady = 1'b0;
  logic [31:0]     irqLines;
  logic [NCH-1:0]  status;
  logic            pitEnable;
  logic            msgValid;
  logic [31:0]     msgAddr;
  logic [31:0]     msgData;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string          req;
    logic [31:0]    lines;
    logic [NCH-1:0] sts;
    logic           pit;
    logic           mv;
    logic [31:0]    ma;
    logic [31:0]    md;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  irq_router #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .legacyEn(legacyEn),
    .chEnable(chEnable), .chLevel(chLevel), .chMsgEn(chMsgEn),
    .chRoute(chRoute), .chMsgRoute(chMsgRoute), .fireStb(fireStb),
    .clearStb(clearStb), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .pitIn(pitIn), .rtcIn(rtcIn), .msgReady(msgReady),
    .irqLines(irqLines), .status(status), .pitEnable(pitEnable),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  // Driver: one clock edge per step, expectation queued for the monitor.
  task automatic step(input string req, input logic [31:0] lines,
                      input logic [NCH-1:0] sts, input logic pit,
                      input logic mv, input logic [31:0] ma, input logic [31:0] md);
    exp_t e;
    @(posedge clk);
    e.req = req; e.lines = lines; e.sts = sts; e.pit = pit;
    e.mv = mv; e.ma = ma; e.md = md;
    q.push_back(e);
    #1;
    fireStb  = '0;
    clearStb = '0;
    stsWrEn  = 1'b0;
  endtask

  // Monitor: compares the state settled after each edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irqLines !== e.lines || status !== e.sts || pitEnable !== e.pit ||
          msgValid !== e.mv || (e.mv && (msgAddr !== e.ma || msgData !== e.md))) begin
        bad++;
        $display("FAIL %s: lines=%h sts=%b pit=%b mv=%b addr=%h data=%h | expected lines=%h sts=%b pit=%b mv=%b addr=%h data=%h",
                 e.req, irqLines, status, pitEnable, msgValid, msgAddr, msgData,
                 e.lines, e.sts, e.pit, e.mv, e.ma, e.md);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    chRoute = {5'd20, 5'd10, 5'd5, 5'd3};
    chMsgRoute = '0;
    chMsgRoute[3*64 +: 64] = {32'hA000_0030, 32'hD000_0003};
    chMsgRoute[2*64 +: 64] = {32'hA000_0020, 32'hD000_0002};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    step("R11 reset state", 32'h0, 4'b0000, 1, 0, 0, 0);
    globalEn = 1; chEnable = 4'hF; chLevel = 4'b0011;
    step("R2 idle after enable", 32'h0, 4'b0000, 1, 0, 0, 0);
    fireStb = 4'b0001;
    step("R2 level fire sets status and line", 32'h8, 4'b0001, 1, 0, 0, 0);
    step("R2 level line held", 32'h8, 4'b0001, 1, 0, 0, 0);
    fireStb = 4'b0100;
    step("R2 edge fire pulses line", 32'h408, 4'b0001, 1, 0, 0, 0);
    step("R2 edge pulse lasts one cycle", 32'h8, 4'b0001, 1, 0, 0, 0);
    fireStb = 4'b0010;
    step("R2 second level channel", 32'h28, 4'b0011, 1, 0, 0, 0);
    stsWrEn = 1; stsWrData = 4'b1101;
    step("R5 write clears only set ones", 32'h20, 4'b0010, 1, 0, 0, 0);
    clearStb = 4'b0010;
    step("R4 clear strobe", 32'h0, 4'b0000, 1, 0, 0, 0);
    fireStb = 4'b0001;
    step("R2 refire", 32'h8, 4'b0001, 1, 0, 0, 0);
    chEnable = 4'hE;
    step("R4 channel disable", 32'h0, 4'b0000, 1, 0, 0, 0);
    chEnable = 4'hF;
    step("R4 re-enable no effect", 32'h0, 4'b0000, 1, 0, 0, 0);
    fireStb = 4'b0001;
    step("R2 fire before global off", 32'h8, 4'b0001, 1, 0, 0, 0);
    globalEn = 0;
    step("R4 global disable", 32'h0, 4'b0000, 1, 0, 0, 0);
    fireStb = 4'b0001;
    step("R4 fire ignored while global off", 32'h0, 4'b0000, 1, 0, 0, 0);
    globalEn = 1;
    step("R4 global back on", 32'h0, 4'b0000, 1, 0, 0, 0);
    pitIn = 1; rtcIn = 1;
    step("R8 pass-through", 32'h101, 4'b0000, 1, 0, 0, 0);
    legacyEn = 1;
    step("R6 enter legacy", 32'h0, 4'b0000, 0, 0, 0, 0);
    fireStb = 4'b0111;
    step("R1 legacy routing", 32'h501, 4'b0011, 0, 0, 0, 0);
    pitIn = 0; rtcIn = 0;
    step("R1 legacy lines held", 32'h101, 4'b0011, 0, 0, 0, 0);
    rtcIn = 1;
    step("R8 inputs blocked in legacy", 32'h101, 4'b0011, 0, 0, 0, 0);
    legacyEn = 0;
    step("R7 leave legacy restores rtc", 32'h100, 4'b0011, 1, 0, 0, 0);
    stsWrEn = 1; stsWrData = 4'b0011; rtcIn = 0;
    step("R5 write clears both", 32'h0, 4'b0000, 1, 0, 0, 0);
    chLevel = 4'b1011; fireStb = 4'b1000;
    step("R2 channel 3 level", 32'h100000, 4'b1000, 1, 0, 0, 0);
    chMsgEn = 4'b1000;
    step("R10 message enable deasserts", 32'h0, 4'b0000, 1, 0, 0, 0);
    fireStb = 4'b1000;
    step("R3 message issued", 32'h0, 4'b0000, 1, 1, 32'hA000_0030, 32'hD000_0003);
    chMsgEn = 4'b1100; fireStb = 4'b0100;
    step("R9 message held while not ready", 32'h0, 4'b0000, 1, 1, 32'hA000_0030, 32'hD000_0003);
    msgReady = 1;
    step("R9 queued message follows", 32'h0, 4'b0000, 1, 1, 32'hA000_0020, 32'hD000_0002);
    step("R9 port drains", 32'h0, 4'b0000, 1, 0, 0, 0);
    msgReady = 0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule